// File: doc/BRIEF.md
# Pointer Cache Prefetch Engine

This block holds a small set-associative table that links the effective address of a pointer load to the base address of the object that the pointer refers to. Each retired pointer load trains the table with the address it loaded from and the pointer value it got back. If the address is already present, the stored base is overwritten. Otherwise the block allocates a way in the set, choosing an invalid way first and the least recently used way when the set is full.

A load that misses the L1 data cache is presented on the lookup port. One cycle later, a hit raises a prediction strobe and returns the stored base, so that dependent operations can proceed on the predicted value. In the same edge, the block queues two prefetch requests: the base rounded down to a line boundary, then the next line. The requests leave through a small FIFO with a ready/valid handshake. If the FIFO cannot take both requests, it takes neither, and a saturating drop counter is incremented.

Top module: `ptrc_engine`

## Requirements
- R1: After reset, `pred_valid_o` and `pf_valid_o` are 0, `drop_cnt_o` is 0, and every table entry is invalid, so a lookup of any address misses.
- R2: A lookup with `lk_valid_i` and `lk_l1_miss_i` both high, to an address that was trained, raises `pred_valid_o` for exactly the next cycle. In that cycle `pred_base_o` carries the most recently trained base for that address.
- R3: A lookup with `lk_l1_miss_i` low produces no prediction and no prefetch request.
- R4: A lookup to an address that is not in the table produces no prediction and no prefetch request.
- R5: A hit queues two requests in this order: the base with its low log2(LINE_BYTES) bits (6 by default) cleared, then that address plus LINE_BYTES, modulo 2^32.
- R6: Training an address that is already present replaces its base in place. It allocates no second entry, so a set still holds WAYS distinct addresses after a retrain.
- R7: The set index is address bits [7:2]. Training a new address into a full set evicts the least recently used way, where both a training write and a lookup hit mark a way as most recently used.
- R8: When a training write and a lookup arrive in the same cycle, the lookup sees the table contents from before that write.
- R9: If fewer than two FIFO slots are free when a hit occurs, counted before any pop in that cycle, both requests are discarded and `drop_cnt_o` increases by one, saturating at its maximum. The prediction for that hit is still given.
- R10: While `pf_valid_o` is high and `pf_ready_i` is low, `pf_valid_o` stays high and `pf_addr_o` holds its value. The FIFO never holds more than PF_DEPTH entries.
- R11: `pf_valid_o` is high whenever the FIFO is not empty. Requests leave in the order they were queued, one per cycle in which both valid and ready are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tr_valid_i | input | 1 | Training write strobe from a retired pointer load |
| tr_addr_i | input | 32 | Effective address of the pointer load |
| tr_base_i | input | 32 | Pointer value (object base) that was loaded |
| lk_valid_i | input | 1 | Lookup strobe |
| lk_l1_miss_i | input | 1 | Lookup load missed the L1 data cache |
| lk_addr_i | input | 32 | Effective address of the lookup load |
| pred_valid_o | output | 1 | Prediction strobe, one cycle after a hitting lookup |
| pred_base_o | output | 32 | Predicted load value (object base) |
| pf_valid_o | output | 1 | Prefetch request available |
| pf_addr_o | output | 32 | Line-aligned prefetch address |
| pf_ready_i | input | 1 | Consumer accepts the prefetch request |
| drop_cnt_o | output | 16 | Saturating count of hits whose prefetches were discarded |

## Verification
The prediction strobe, the predicted base and the drop counter are all due at the first rising edge after the cycle in which the lookup is presented. The first prefetch request appears at the FIFO head at that same edge. Each pop moves the next request to the head one edge later. The bench changes inputs on the falling edge and samples results on the next falling edge, which is half a cycle after the edge that produces them. It waits one further edge after each pop, so every check looks at the cycle its result is due.

// File: rtl/ptrc_pkg.sv
`timescale 1ns/1ps
package ptrc_pkg;
  localparam int unsigned PTRC_AW = 32;
  typedef logic [PTRC_AW-1:0] ptrc_addr_t;
endpackage

// File: rtl/ptrc_lru.sv
`timescale 1ns/1ps
module ptrc_lru #(
  parameter int unsigned SETS  = 64,
  parameter int unsigned WAYS  = 4,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned AGE_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tch_a_i,
  input  logic [IDX_W-1:0] set_a_i,
  input  logic [AGE_W-1:0] way_a_i,
  input  logic             tch_b_i,
  input  logic [IDX_W-1:0] set_b_i,
  input  logic [AGE_W-1:0] way_b_i,
  input  logic [IDX_W-1:0] qset_i,
  output logic [AGE_W-1:0] lru_way_o
);
  // age 0 = most recent; ages within a set stay a permutation
  logic [AGE_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (tch_a_i && set_a_i == IDX_W'(s)) begin
          for (int w = 0; w < WAYS; w++) begin
            if (AGE_W'(w) == way_a_i) age_q[s][w] <= '0;
            else if (age_q[s][w] < age_q[s][way_a_i]) age_q[s][w] <= age_q[s][w] + AGE_W'(1);
          end
        end else if (tch_b_i && set_b_i == IDX_W'(s)) begin
          // train touch wins when both hit one set
          for (int w = 0; w < WAYS; w++) begin
            if (AGE_W'(w) == way_b_i) age_q[s][w] <= '0;
            else if (age_q[s][w] < age_q[s][way_b_i]) age_q[s][w] <= age_q[s][w] + AGE_W'(1);
          end
        end
      end
    end
  end

  always_comb begin
    lru_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[qset_i][w] == AGE_W'(WAYS-1)) lru_way_o = AGE_W'(w);
  end
endmodule

// File: rtl/ptrc_tbl.sv
`timescale 1ns/1ps
module ptrc_tbl
  import ptrc_pkg::*;
#(
  parameter int unsigned SETS    = 64,
  parameter int unsigned WAYS    = 4,
  parameter int unsigned IDX_LSB = 2,
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned WAY_W  = $clog2(WAYS)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tr_valid_i,
  input  ptrc_addr_t tr_addr_i,
  input  ptrc_addr_t tr_base_i,
  input  logic       lk_en_i,
  input  ptrc_addr_t lk_addr_i,
  output logic       lk_hit_o,
  output ptrc_addr_t lk_base_o
);
  logic       vld_q  [SETS][WAYS];
  ptrc_addr_t tag_q  [SETS][WAYS];
  ptrc_addr_t base_q [SETS][WAYS];

  logic [IDX_W-1:0] tr_set, lk_set;
  logic [WAY_W-1:0] tr_way, free_way, lru_way, alloc_way, lk_way;
  logic             tr_hit, any_free;

  assign tr_set = tr_addr_i[IDX_LSB +: IDX_W];
  assign lk_set = lk_addr_i[IDX_LSB +: IDX_W];

  // lowest matching way wins on lookup
  always_comb begin
    lk_hit_o  = 1'b0;
    lk_way    = '0;
    lk_base_o = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (vld_q[lk_set][w] && tag_q[lk_set][w] == lk_addr_i) begin
        lk_hit_o  = 1'b1;
        lk_way    = WAY_W'(w);
        lk_base_o = base_q[lk_set][w];
      end
    end
  end

  always_comb begin
    tr_hit   = 1'b0;
    tr_way   = '0;
    any_free = 1'b0;
    free_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (vld_q[tr_set][w] && tag_q[tr_set][w] == tr_addr_i) begin
        tr_hit = 1'b1;
        tr_way = WAY_W'(w);
      end
      if (!vld_q[tr_set][w]) begin
        any_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    alloc_way = tr_hit ? tr_way : (any_free ? free_way : lru_way);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          vld_q[s][w] <= 1'b0;
    end else if (tr_valid_i) begin
      vld_q[tr_set][alloc_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (tr_valid_i) begin
      tag_q[tr_set][alloc_way]  <= tr_addr_i;
      base_q[tr_set][alloc_way] <= tr_base_i;
    end
  end

  ptrc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tch_a_i   (tr_valid_i),
    .set_a_i   (tr_set),
    .way_a_i   (alloc_way),
    .tch_b_i   (lk_en_i && lk_hit_o),
    .set_b_i   (lk_set),
    .way_b_i   (lk_way),
    .qset_i    (tr_set),
    .lru_way_o (lru_way)
  );
endmodule

// File: rtl/ptrc_pf_fifo.sv
`timescale 1ns/1ps
module ptrc_pf_fifo
  import ptrc_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH+1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push2_i,
  input  ptrc_addr_t       d0_i,
  input  ptrc_addr_t       d1_i,
  input  logic             ready_i,
  output logic             valid_o,
  output ptrc_addr_t       data_o,
  output logic             room2_o,
  output logic [CNT_W-1:0] cnt_o
);
  ptrc_addr_t       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop;

  assign valid_o = cnt_q != '0;
  assign data_o  = mem_q[rd_q];
  assign room2_o = (CNT_W'(DEPTH) - cnt_q) >= CNT_W'(2);
  assign cnt_o   = cnt_q;
  assign pop     = valid_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push2_i) wr_q <= wr_q + PTR_W'(2);
      if (pop)     rd_q <= rd_q + PTR_W'(1);
      cnt_q <= cnt_q + (push2_i ? CNT_W'(2) : CNT_W'(0)) - (pop ? CNT_W'(1) : CNT_W'(0));
    end
  end

  always_ff @(posedge clk_i) begin
    if (push2_i) begin
      mem_q[wr_q]              <= d0_i;
      mem_q[wr_q + PTR_W'(1)]  <= d1_i;
    end
  end
endmodule

// File: rtl/ptrc_engine.sv
`timescale 1ns/1ps
module ptrc_engine
  import ptrc_pkg::*;
#(
  parameter int unsigned SETS       = 64,
  parameter int unsigned WAYS       = 4,
  parameter int unsigned IDX_LSB    = 2,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned PF_DEPTH   = 4,
  parameter int unsigned DROP_W     = 16,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned CNT_W     = $clog2(PF_DEPTH+1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tr_valid_i,
  input  logic [31:0]       tr_addr_i,
  input  logic [31:0]       tr_base_i,
  input  logic              lk_valid_i,
  input  logic              lk_l1_miss_i,
  input  logic [31:0]       lk_addr_i,
  output logic              pred_valid_o,
  output logic [31:0]       pred_base_o,
  output logic              pf_valid_o,
  output logic [31:0]       pf_addr_o,
  input  logic              pf_ready_i,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic             lk_en, tbl_hit, hit_now, room2, push2, drop;
  ptrc_addr_t       tbl_base, line0, line1;
  logic [CNT_W-1:0] pf_cnt;
  logic             pred_valid_q;
  ptrc_addr_t       pred_base_q;
  logic [DROP_W-1:0] drop_q;

  assign lk_en   = lk_valid_i && lk_l1_miss_i;
  assign hit_now = lk_en && tbl_hit;
  assign line0   = {tbl_base[PTRC_AW-1:OFF_W], OFF_W'(0)};
  assign line1   = line0 + PTRC_AW'(LINE_BYTES);
  assign push2   = hit_now && room2;
  assign drop    = hit_now && !room2;

  ptrc_tbl #(.SETS(SETS), .WAYS(WAYS), .IDX_LSB(IDX_LSB)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tr_valid_i (tr_valid_i),
    .tr_addr_i  (tr_addr_i),
    .tr_base_i  (tr_base_i),
    .lk_en_i    (lk_en),
    .lk_addr_i  (lk_addr_i),
    .lk_hit_o   (tbl_hit),
    .lk_base_o  (tbl_base)
  );

  ptrc_pf_fifo #(.DEPTH(PF_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push2_i (push2),
    .d0_i    (line0),
    .d1_i    (line1),
    .ready_i (pf_ready_i),
    .valid_o (pf_valid_o),
    .data_o  (pf_addr_o),
    .room2_o (room2),
    .cnt_o   (pf_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_q <= 1'b0;
      pred_base_q  <= '0;
      drop_q       <= '0;
    end else begin
      pred_valid_q <= hit_now;
      if (hit_now) pred_base_q <= tbl_base;
      if (drop && drop_q != '1) drop_q <= drop_q + DROP_W'(1);
    end
  end

  assign pred_valid_o = pred_valid_q;
  assign pred_base_o  = pred_base_q;
  assign drop_cnt_o   = drop_q;
endmodule

// File: rtl/ptrc_chk.sv
`timescale 1ns/1ps
module ptrc_chk #(
  parameter int unsigned PF_DEPTH   = 4,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned DROP_W     = 16,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned CNT_W     = $clog2(PF_DEPTH+1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lk_valid_i,
  input logic              lk_l1_miss_i,
  input logic              pred_valid_o,
  input logic              pf_valid_o,
  input logic [31:0]       pf_addr_o,
  input logic              pf_ready_i,
  input logic [DROP_W-1:0] drop_cnt_o,
  input logic [CNT_W-1:0]  pf_cnt_i
);
  AST_PRED_NEEDS_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> $past(lk_valid_i && lk_l1_miss_i)); // R3
  AST_HIT_LEAVES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> pf_valid_o); // R5
  AST_PF_LINE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o |-> pf_addr_o[OFF_W-1:0] == '0); // R5
  AST_PF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_valid_o && !pf_ready_i) |=> (pf_valid_o && $stable(pf_addr_o))); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_cnt_i <= CNT_W'(PF_DEPTH)); // R10
  AST_DROP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_o == $past(drop_cnt_o)) || (drop_cnt_o == $past(drop_cnt_o) + DROP_W'(1))); // R9
  AST_DROP_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_o != $past(drop_cnt_o)) |-> ($past(pf_cnt_i) > CNT_W'(PF_DEPTH-2))); // R9
endmodule

bind ptrc_engine ptrc_chk #(.PF_DEPTH(PF_DEPTH), .LINE_BYTES(LINE_BYTES), .DROP_W(DROP_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lk_valid_i   (lk_valid_i),
  .lk_l1_miss_i (lk_l1_miss_i),
  .pred_valid_o (pred_valid_o),
  .pf_valid_o   (pf_valid_o),
  .pf_addr_o    (pf_addr_o),
  .pf_ready_i   (pf_ready_i),
  .drop_cnt_o   (drop_cnt_o),
  .pf_cnt_i     (pf_cnt)
);

// File: tb/tb_ptrc_engine.sv
`timescale 1ns/1ps
module tb_ptrc_engine;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tr_valid_i = 1'b0;
  logic [31:0] tr_addr_i = '0, tr_base_i = '0;
  logic        lk_valid_i = 1'b0, lk_l1_miss_i = 1'b0;
  logic [31:0] lk_addr_i = '0;
  logic        pred_valid_o, pf_valid_o;
  logic [31:0] pred_base_o, pf_addr_o;
  logic        pf_ready_i = 1'b0;
  logic [15:0] drop_cnt_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ptrc_engine dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .tr_valid_i(tr_valid_i), .tr_addr_i(tr_addr_i), .tr_base_i(tr_base_i),
    .lk_valid_i(lk_valid_i), .lk_l1_miss_i(lk_l1_miss_i), .lk_addr_i(lk_addr_i),
    .pred_valid_o(pred_valid_o), .pred_base_o(pred_base_o),
    .pf_valid_o(pf_valid_o), .pf_addr_o(pf_addr_o), .pf_ready_i(pf_ready_i),
    .drop_cnt_o(drop_cnt_o)
  );

  function automatic logic [31:0] mk_addr(input logic [23:0] t, input int s);
    return {t, 6'(s), 2'b00};
  endfunction
  function automatic logic [31:0] base_of(input int s);
    if (s == 63) return 32'hFFFF_FFF0;
    return 32'h2000_0000 + 32'(s) * 32'h0001_0104 + 32'h1D;
  endfunction
  function automatic logic [31:0] ln0(input logic [31:0] b);
    return b & 32'hFFFF_FFC0;
  endfunction

  task automatic check(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (ok !== 1'b1) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
  endtask

  task automatic train(input logic [31:0] a, input logic [31:0] b);
    tr_valid_i = 1'b1; tr_addr_i = a; tr_base_i = b;
    @(posedge clk); @(negedge clk);
    tr_valid_i = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] a, input logic miss, input logic exp_hit,
                        input logic [31:0] exp_base, input string rq);
    lk_valid_i = 1'b1; lk_l1_miss_i = miss; lk_addr_i = a;
    @(posedge clk); @(negedge clk);
    lk_valid_i = 1'b0; lk_l1_miss_i = 1'b0;
    check(pred_valid_o === exp_hit, rq, 32'(pred_valid_o), 32'(exp_hit));
    if (exp_hit) check(pred_base_o === exp_base, rq, pred_base_o, exp_base);
  endtask

  task automatic pop_expect(input logic [31:0] exp, input string rq);
    check(pf_valid_o === 1'b1, rq, 32'(pf_valid_o), 32'd1);
    check(pf_addr_o === exp, rq, pf_addr_o, exp);
    pf_ready_i = 1'b1;
    @(posedge clk); @(negedge clk);
    pf_ready_i = 1'b0;
  endtask

  task automatic drain_all();
    pf_ready_i = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk) pf_ready_i = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check(pred_valid_o === 1'b0, "R1", 32'(pred_valid_o), 0);
    check(pf_valid_o === 1'b0, "R1", 32'(pf_valid_o), 0);
    check(drop_cnt_o === 16'd0, "R1", 32'(drop_cnt_o), 0);

    // sweep every set
    for (int s = 0; s < 64; s++) train(mk_addr(24'h100 + 24'(s), s), base_of(s));
    for (int s = 0; s < 64; s++) begin
      lookup(mk_addr(24'h100 + 24'(s), s), 1'b0, 1'b0, '0, "R3");
      check(pf_valid_o === 1'b0, "R3", 32'(pf_valid_o), 0);
      lookup(mk_addr(24'hABC, s), 1'b1, 1'b0, '0, "R4");
      check(pf_valid_o === 1'b0, "R4", 32'(pf_valid_o), 0);
      lookup(mk_addr(24'h100 + 24'(s), s), 1'b1, 1'b1, base_of(s), "R2");
      pop_expect(ln0(base_of(s)), "R5");
      pop_expect(ln0(base_of(s)) + 32'd64, "R5");
      check(pf_valid_o === 1'b0, "R11", 32'(pf_valid_o), 0);
    end

    // R8 same-cycle train and lookup
    tr_valid_i = 1'b1; tr_addr_i = mk_addr(24'h114, 20); tr_base_i = 32'hCAFE_0000;
    lk_valid_i = 1'b1; lk_l1_miss_i = 1'b1; lk_addr_i = mk_addr(24'h114, 20);
    @(posedge clk); @(negedge clk);
    tr_valid_i = 1'b0; lk_valid_i = 1'b0; lk_l1_miss_i = 1'b0;
    check(pred_valid_o === 1'b1, "R8", 32'(pred_valid_o), 1);
    check(pred_base_o === base_of(20), "R8", pred_base_o, base_of(20));
    drain_all();
    lookup(mk_addr(24'h114, 20), 1'b1, 1'b1, 32'hCAFE_0000, "R8");
    drain_all();
    tr_valid_i = 1'b1; tr_addr_i = mk_addr(24'h777, 21); tr_base_i = 32'h0000_4440;
    lk_valid_i = 1'b1; lk_l1_miss_i = 1'b1; lk_addr_i = mk_addr(24'h777, 21);
    @(posedge clk); @(negedge clk);
    tr_valid_i = 1'b0; lk_valid_i = 1'b0; lk_l1_miss_i = 1'b0;
    check(pred_valid_o === 1'b0, "R8", 32'(pred_valid_o), 0);
    lookup(mk_addr(24'h777, 21), 1'b1, 1'b1, 32'h0000_4440, "R8");
    drain_all();

    // R9 / R10 / R11 FIFO pressure
    lookup(mk_addr(24'h10A, 10), 1'b1, 1'b1, base_of(10), "R9");
    lookup(mk_addr(24'h10B, 11), 1'b1, 1'b1, base_of(11), "R9");
    check(drop_cnt_o === 16'd0, "R9", 32'(drop_cnt_o), 0);
    lookup(mk_addr(24'h10C, 12), 1'b1, 1'b1, base_of(12), "R9");
    check(drop_cnt_o === 16'd1, "R9", 32'(drop_cnt_o), 1);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      check(pf_valid_o === 1'b1 && pf_addr_o === ln0(base_of(10)), "R10", pf_addr_o, ln0(base_of(10)));
    end
    pop_expect(ln0(base_of(10)), "R11");
    lookup(mk_addr(24'h10D, 13), 1'b1, 1'b1, base_of(13), "R9");
    check(drop_cnt_o === 16'd2, "R9", 32'(drop_cnt_o), 2);
    pop_expect(ln0(base_of(10)) + 32'd64, "R11");
    pop_expect(ln0(base_of(11)), "R11");
    pop_expect(ln0(base_of(11)) + 32'd64, "R11");
    check(pf_valid_o === 1'b0, "R11", 32'(pf_valid_o), 0);
    lookup(mk_addr(24'h10E, 14), 1'b1, 1'b1, base_of(14), "R9");
    pop_expect(ln0(base_of(14)), "R11");
    pop_expect(ln0(base_of(14)) + 32'd64, "R11");
    check(drop_cnt_o === 16'd2, "R9", 32'(drop_cnt_o), 2);
    // R5 wrap at top of address space
    lookup(mk_addr(24'h13F, 63), 1'b1, 1'b1, 32'hFFFF_FFF0, "R5");
    pop_expect(32'hFFFF_FFC0, "R5");
    pop_expect(32'h0000_0000, "R5");

    // R1 table cleared by reset
    do_reset();
    lookup(mk_addr(24'h103, 3), 1'b1, 1'b0, '0, "R1");
    check(drop_cnt_o === 16'd0, "R1", 32'(drop_cnt_o), 0);

    // R6 retrain in place
    train(mk_addr(24'h001, 9), 32'h0000_1000);
    train(mk_addr(24'h001, 9), 32'h0000_2000);
    lookup(mk_addr(24'h001, 9), 1'b1, 1'b1, 32'h0000_2000, "R6");
    train(mk_addr(24'h002, 9), 32'h0000_3000);
    train(mk_addr(24'h003, 9), 32'h0000_4000);
    train(mk_addr(24'h004, 9), 32'h0000_5000);
    drain_all();
    for (int t = 1; t <= 4; t++) begin
      lookup(mk_addr(24'(t), 9), 1'b1, 1'b1, 32'h0000_1000 * 32'(t + (t == 1 ? 1 : 1)), "R6");
      drain_all();
    end

    // R7 LRU victim
    do_reset();
    for (int t = 0; t < 4; t++) train(mk_addr(24'h50 + 24'(t), 5), 32'h0001_0000 + 32'(t) * 32'h100);
    lookup(mk_addr(24'h50, 5), 1'b1, 1'b1, 32'h0001_0000, "R7");
    drain_all();
    train(mk_addr(24'h54, 5), 32'h0001_0400);
    lookup(mk_addr(24'h51, 5), 1'b1, 1'b0, '0, "R7");
    for (int t = 0; t < 5; t++) begin
      if (t == 1) continue;
      lookup(mk_addr(24'h50 + 24'(t), 5), 1'b1, 1'b1, 32'h0001_0000 + 32'(t) * 32'h100, "R7");
      drain_all();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule